// File: doc/BRIEF.md
# Two-Wire Row-Addressed Storage Slave

This block is the slave end of a two-wire serial bus that fronts a small store of 32 rows of 16 bits. The master supplies the clock on SCL and the slave shares the open-drain SDA line. The slave reads the line through `sda_i` and pulls it low by raising `sda_oe`. Both bus lines are oversampled on the system clock through two-flop synchronizers, so bus events are seen a few system cycles after they happen on the wires.

A transfer opens with a START event, which is SDA falling while SCL is high. It closes with a STOP event, which is SDA rising while SCL is high. The first byte after START is a control byte that holds a row number, two mode bits and a direction bit. It carries no device address. A write then takes two data bytes, the high byte first. A read returns the high byte and then the low byte of the row. Every byte travels MSB first. The slave acknowledges each byte it receives. While it transmits, it stops sending as soon as the master withholds its acknowledge. Outside a transfer the block is in standby and leaves SDA undriven.

Top module: `twi_row_store_slave`

## Requirements
- R1: After reset, `standby_o` is 1, `sda_oe` is 0, `mode_o` is 00 and every row reads back as 0x0000.
- R2: A START event (SDA falling while SCL is high) clears `standby_o`. A STOP event (SDA rising while SCL is high) sets `standby_o` and releases SDA, whatever point the transfer has reached.
- R3: In the control byte, bits 7..3 give the row, bits 2..1 are mode bits that appear on `mode_o`, and bit 0 gives the direction (0 = write, 1 = read).
- R4: The slave holds SDA low for the whole ninth clock that follows the control byte and each of the two write data bytes.
- R5: A write shifts in two data bytes MSB first. The first byte becomes bits 15..8 of the addressed row and the second byte becomes bits 7..0.
- R6: A read drives bits 15..8 of the row and then bits 7..0 onto SDA, MSB first, and leaves SDA free on each byte's ninth clock.
- R7: If the master does not acknowledge (SDA high on the ninth clock) after a read byte, the slave sends no more data and leaves SDA released until the next START or STOP.
- R8: A STOP that arrives part way through a write data byte leaves the addressed row unchanged.
- R9: A START part way through a byte discards the partial byte. The next eight bits are then taken as a fresh control byte.
- R10: Bytes that follow the second write data byte are not acknowledged and do not change any row.
- R11: SDA is never driven while the block is in standby.
- R12: The mode bits have no effect on what is stored or what is read back.
- R13: `sda_oe` changes only in the cycle after a synchronized SCL falling edge, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the master |
| sda_i | input | 1 | Level read back from the shared data line |
| sda_oe | output | 1 | 1 pulls the data line low |
| standby_o | output | 1 | 1 while no transfer is open |
| mode_o | output | 2 | Mode bits from the most recent control byte |

## Verification
The bench goes after five cases. The first is a START inside a partial byte: a design that kept the stale bits would decode the wrong row and write into it. The second is a STOP inside the first data byte: a design that committed the half-received data would corrupt the row. The third is a master NACK after the first read byte: a design that kept transmitting would pull SDA low in the following clocks, and the bench would see a byte other than 0xFF. The fourth is a surplus third write byte: an extra acknowledge or a changed row exposes a design that kept counting bytes. Finally, writes and reads use different mode bits, so a design that let the mode bits reach the data path would return the wrong data.

// File: rtl/twi_row_store_slave.sv
module twi_row_store_slave #(
  parameter int ROWS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       standby_o,
  output logic [1:0] mode_o
);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_WR, S_RD, S_HOLD} st_t;

  logic [2:0] scl_q, sda_q;
  logic scl_s, scl_p, sda_s, sda_p;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  st_t             st;
  logic [3:0]      bitcnt;
  logic [7:0]      shreg;
  logic            ack_ph;
  logic            byte_idx;
  logic            dir_rd;
  logic [ROW_W-1:0] row;
  logic [7:0]      hi_buf;
  logic [WORD_W-1:0] mem [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_s    = scl_q[1];
  assign scl_p    = scl_q[2];
  assign sda_s    = sda_q[1];
  assign sda_p    = sda_q[2];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

  assign standby_o = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      ack_ph   <= 1'b0;
      byte_idx <= 1'b0;
      dir_rd   <= 1'b0;
      row      <= '0;
      hi_buf   <= '0;
      mode_o   <= '0;
      sda_oe   <= 1'b0;
      for (int i = 0; i < ROWS; i++) mem[i] <= '0;
    end else if (stop_ev) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
      ack_ph <= 1'b0;
      bitcnt <= '0;
    end else if (start_ev) begin
      st       <= S_CTRL;
      sda_oe   <= 1'b0;
      ack_ph   <= 1'b0;
      bitcnt   <= '0;
      byte_idx <= 1'b0;
    end else begin
      case (st)
        S_CTRL, S_WR: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8 && !ack_ph) begin
            ack_ph <= 1'b1;
            sda_oe <= 1'b1;
            if (st == S_CTRL) begin
              row    <= shreg[7 -: ROW_W];
              mode_o <= shreg[2:1];
              dir_rd <= shreg[0];
            end else if (!byte_idx) begin
              hi_buf <= shreg;
            end else begin
              mem[row] <= {hi_buf, shreg};
            end
          end else if (scl_fall && ack_ph) begin
            ack_ph <= 1'b0;
            bitcnt <= '0;
            if (st == S_CTRL && dir_rd) begin
              st       <= S_RD;
              shreg    <= mem[row][15:8];
              byte_idx <= 1'b0;
              sda_oe   <= ~mem[row][15];
            end else if (st == S_CTRL) begin
              st       <= S_WR;
              byte_idx <= 1'b0;
              sda_oe   <= 1'b0;
            end else if (!byte_idx) begin
              byte_idx <= 1'b1;
              sda_oe   <= 1'b0;
            end else begin
              st     <= S_HOLD;
              sda_oe <= 1'b0;
            end
          end
        end
        S_RD: begin
          if (scl_rise && bitcnt < 4'd8) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_rise) begin
            if (!sda_s && !byte_idx) begin
              shreg    <= mem[row][7:0];
              byte_idx <= 1'b1;
              bitcnt   <= '0;
            end else begin
              st <= S_HOLD;
            end
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) sda_oe <= 1'b0;
            else                sda_oe <= ~shreg[3'd7 - bitcnt[2:0]];
          end
        end
        default: ;
      endcase
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    standby_o |-> !sda_oe); // R11
  AST_START_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && !stop_ev) |=> !standby_o); // R2
  AST_STOP_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (standby_o && !sda_oe)); // R2
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD) |-> !sda_oe); // R10
  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_ev || stop_ev)); // R13
  AST_NO_DRIVE_SCL_HIGH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |=> $stable(sda_oe)); // R13
endmodule

// File: tb/twi_row_store_slave_tb.sv
module twi_row_store_slave_tb;
  localparam int Q = 6;
  localparam int NV = 6;
  localparam logic [22:0] VEC [NV] = '{
    {5'd0,  2'b00, 16'hA55A},
    {5'd31, 2'b11, 16'h0001},
    {5'd9,  2'b01, 16'h8000},
    {5'd16, 2'b10, 16'hFFFF},
    {5'd3,  2'b11, 16'h1234},
    {5'd22, 2'b01, 16'hC3E7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe, standby_o;
  logic [1:0] mode_o;
  wire sda_line = ~(sda_oe | m_low);
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  twi_row_store_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .standby_o(standby_o), .mode_o(mode_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq(); scl = 1'b1; wq(); m_low = 1'b1; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(); scl = 1'b1; wq(); m_low = 1'b0; wq();
  endtask

  task automatic bit_io(input logic b, output logic seen);
    m_low = !b; wq(); scl = 1'b1; wq(); seen = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic byte_io(input logic [7:0] tx, input logic tx9, output logic [7:0] rx, output logic rx9);
    for (int i = 7; i >= 0; i--) bit_io(tx[i], rx[i]);
    bit_io(tx9, rx9);
  endtask

  task automatic write_row(input logic [4:0] r, input logic [1:0] m, input logic [15:0] d, output logic [2:0] acks);
    logic [7:0] junk;
    bus_start();
    byte_io({r, m, 1'b0}, 1'b1, junk, acks[2]);
    byte_io(d[15:8], 1'b1, junk, acks[1]);
    byte_io(d[7:0], 1'b1, junk, acks[0]);
    bus_stop();
  endtask

  task automatic read_row(input logic [4:0] r, input logic [1:0] m, output logic [15:0] d, output logic a0);
    logic x;
    bus_start();
    byte_io({r, m, 1'b1}, 1'b1, d[15:8], a0);
    byte_io(8'hFF, 1'b0, d[15:8], x);
    byte_io(8'hFF, 1'b1, d[7:0], x);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] acks;
    logic [15:0] rd;
    logic a0, x;
    logic [7:0] rb;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(standby_o === 1'b1, "R1 standby after reset", standby_o, 1);
    chk(sda_oe === 1'b0, "R1 sda released after reset", sda_oe, 0);
    chk(mode_o === 2'b00, "R1 mode after reset", mode_o, 0);
    read_row(5'd12, 2'b00, rd, a0);
    chk(rd === 16'h0000, "R1 row zero after reset", rd, 0);

    for (int v = 0; v < NV; v++) begin
      write_row(VEC[v][22:18], VEC[v][17:16], VEC[v][15:0], acks);
      chk(acks === 3'b000, "R4 acks on ctrl and two write bytes", acks, 0);
      chk(mode_o === VEC[v][17:16], "R3 mode bits after write ctrl", mode_o, VEC[v][17:16]);
      wq();
      chk(standby_o === 1'b1 && sda_oe === 1'b0, "R2 standby after stop (R11)", {standby_o, sda_oe}, 2'b10);
    end
    for (int v = 0; v < NV; v++) begin
      read_row(VEC[v][22:18], ~VEC[v][17:16], rd, a0);
      chk(a0 === 1'b0, "R4 ack on read ctrl byte", a0, 0);
      chk(rd === VEC[v][15:0], "R5 R6 R12 read data high then low", rd, VEC[v][15:0]);
      chk(mode_o === ~VEC[v][17:16], "R3 mode bits after read ctrl", mode_o, ~VEC[v][17:16]);
    end

    bus_start();
    wq();
    chk(standby_o === 1'b0, "R2 start leaves standby", standby_o, 0);
    byte_io({5'd0, 2'b00, 1'b1}, 1'b1, rb, a0);
    byte_io(8'hFF, 1'b1, rb, x);
    chk(rb === 8'hA5, "R6 first read byte before nack", rb, 8'hA5);
    byte_io(8'hFF, 1'b1, rb, x);
    chk(rb === 8'hFF, "R7 no data after master nack", rb, 8'hFF);
    chk(sda_oe === 1'b0, "R7 sda released after nack", sda_oe, 0);
    bus_stop();

    bus_start();
    byte_io({5'd9, 2'b00, 1'b0}, 1'b1, rb, a0);
    for (int i = 0; i < 4; i++) bit_io(1'b0, x);
    bus_stop();
    wq();
    chk(standby_o === 1'b1 && sda_oe === 1'b0, "R8 stop mid byte gives standby", {standby_o, sda_oe}, 2'b10);
    read_row(5'd9, 2'b00, rd, a0);
    chk(rd === 16'h8000, "R8 row unchanged by aborted write", rd, 16'h8000);

    bus_start();
    bit_io(1'b1, x); bit_io(1'b1, x); bit_io(1'b1, x);
    bus_start();
    byte_io({5'd5, 2'b10, 1'b0}, 1'b1, rb, a0);
    chk(a0 === 1'b0, "R9 fresh ctrl byte acked after restart", a0, 0);
    chk(mode_o === 2'b10, "R9 ctrl decoded from fresh bits", mode_o, 2'b10);
    byte_io(8'h5E, 1'b1, rb, x);
    byte_io(8'h71, 1'b1, rb, x);
    bus_stop();
    read_row(5'd5, 2'b00, rd, a0);
    chk(rd === 16'h5E71, "R9 write landed in restarted row", rd, 16'h5E71);
    read_row(5'd28, 2'b00, rd, a0);
    chk(rd === 16'h0000, "R9 stale partial byte did not select a row", rd, 0);

    bus_start();
    byte_io({5'd3, 2'b01, 1'b0}, 1'b1, rb, a0);
    byte_io(8'hDE, 1'b1, rb, x);
    byte_io(8'hAD, 1'b1, rb, x);
    byte_io(8'h00, 1'b1, rb, x);
    chk(x === 1'b1, "R10 third write byte not acked", x, 1);
    bus_stop();
    read_row(5'd3, 2'b00, rd, a0);
    chk(rd === 16'hDEAD, "R10 third byte has no effect", rd, 16'hDEAD);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule